// File: doc/BRIEF.md
# Segmented Data Address Translator

This block turns a logical data offset into a physical address. The 64 KB logical data space is cut into four equal blocks of 16 KB. Each block is steered by its own 16-bit map word. A map word picks one of three targets: unified memory, instruction memory or internal data memory. It can instead pick an I/O mode, in which each 4 KB window of the block lands in its own I/O segment. A requester presents an offset and a byte count. One cycle later it receives the physical address, a space tag, the number of bytes that fit before the end of the block, and an error flag.

The map words are written and read through a small register port that decodes data-space addresses near the top of the 64 KB range. One extra address is a second name for map word 2. Map words come out of reset with fixed values. A build-time switch selects a legacy reset pattern.

Top module: `dtr_xlate`

## Requirements
- R1: After reset, map words 0, 1, 2 and 3 read 0x2000, 0x2000, 0x2000 and 0x0000. With LEGACY_RESET set, map word 2 reads 0x0000 instead.
- R2: A write with reg_wr high to address 0xFF08 + 2n loads map word n, for n from 0 to 3. Address 0xFF04 reads and writes map word 2. A write to any other address changes no map word, and reading any other address returns 0.
- R3: The map word index is offset bits 15:14, and the in-block offset is bits 13:0.
- R4: An offset of 0x10000 or more gives rsp_err = 1, rsp_len = 0, rsp_phys = 0 and rsp_space = 0.
- R5: rsp_len is the smaller of req_len and 0x4000 minus the in-block offset.
- R6: With map bit 15 clear and bits 13:12 = 00, the space tag is 0 (unified). The address is segment × 0x4000 + offset, where the segment is map bits 9:0.
- R7: With map bit 15 clear and bits 13:12 = 01, the space tag is 1 (instruction). The address is formed as in R6.
- R8: With map bit 15 clear and bits 13:12 = 10, the space tag is 2 (internal data). The address is (segment << 16) + index × 0x4000 + offset.
- R9: With map bit 15 clear and bits 13:12 = 11, the result is an error. rsp_err = 1, rsp_len = 0, rsp_phys = 0 and rsp_space = 0.
- R10: With map bit 15 set, the space tag is 3 (I/O) and no error is raised. Let k = (offset bits 13:12). The nibble at map bits [4(3−k)+3 : 4(3−k)] gives the address nibble × 0x10000 + 0xC000 + offset.
- R11: rsp_valid rises one cycle after req_valid. The result uses the map words as they stood before any register write in the request cycle. The result fields hold their values while no request arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Map register write strobe |
| reg_addr | input | 16 | Register port data-space address |
| reg_wdata | input | 16 | Map register write data |
| reg_rdata | output | 16 | Map word at reg_addr, 0 if none |
| req_valid | input | 1 | Translation request strobe |
| req_addr | input | LADDR_W (18) | Logical data offset |
| req_len | input | LEN_W (15) | Requested byte count |
| rsp_valid | output | 1 | Result valid, one cycle after request |
| rsp_phys | output | 26 | Physical address |
| rsp_space | output | 2 | 0 unified, 1 instruction, 2 internal data, 3 I/O |
| rsp_len | output | LEN_W (15) | Bytes that fit before the block boundary |
| rsp_err | output | 1 | Out-of-range offset or reserved space |

## Verification
The assertions assume two things about the inputs. No request arrives while the internal synchronised reset is still asserted. req_len never exceeds what LEN_W can carry. The stimulus meets both. It waits several cycles after reset release before the first request, and draws lengths from a range that covers the whole 16 KB block plus some overshoot. Random offsets sometimes reach above 64 KB, and random map words cover all four space codes and the I/O bit. Directed cases then hit the block edge, zero length, the alias address and a write that lands in the same cycle as a request.

// File: rtl/dtr_pkg.sv
package dtr_pkg;

  localparam int MAP_W       = 16;
  localparam int SEG_W       = 10;
  localparam int SPC_LSB     = 12;
  localparam int IO_BIT      = 15;
  localparam int IO_WIN_LSB  = 12;

  typedef enum logic [1:0] {
    SPC_UNIFIED = 2'd0,
    SPC_INSN    = 2'd1,
    SPC_DATA    = 2'd2,
    SPC_IO      = 2'd3
  } space_e;

  function automatic logic [MAP_W-1:0] map_reset_value(input int idx, input bit legacy);
    logic [MAP_W-1:0] v;
    case (idx)
      0, 1:    v = 16'h2000;
      2:       v = legacy ? 16'h0000 : 16'h2000;
      default: v = 16'h0000;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/dtr_map_regs.sv
module dtr_map_regs
  import dtr_pkg::*;
#(
  parameter int          NUM_MAPS     = 4,
  parameter bit          LEGACY_RESET = 1'b0,
  parameter logic [15:0] MAP_BASE     = 16'hFF08,
  parameter logic [15:0] ALIAS_ADDR   = 16'hFF04,
  parameter int          ALIAS_IDX    = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr,
  input  logic [15:0]                    addr,
  input  logic [MAP_W-1:0]               wdata,
  output logic [MAP_W-1:0]               rdata,
  output logic [NUM_MAPS-1:0][MAP_W-1:0] map_vals
);

  logic [NUM_MAPS-1:0] sel;

  for (genvar g = 0; g < NUM_MAPS; g++) begin : g_map
    localparam logic [MAP_W-1:0] RST_VAL  = map_reset_value(g, LEGACY_RESET);
    localparam logic [15:0]      OWN_ADDR = 16'(MAP_BASE + 16'(2 * g));
    localparam bit               HAS_ALIAS = (g == ALIAS_IDX);

    logic             load;
    logic [MAP_W-1:0] map_q;

    assign sel[g] = (addr == OWN_ADDR) || (HAS_ALIAS && (addr == ALIAS_ADDR));
    assign load   = wr && sel[g];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        map_q <= RST_VAL;
      end else if (load) begin
        map_q <= wdata;
      end
    end

    assign map_vals[g] = map_q;
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NUM_MAPS; i++) begin
      if (sel[i]) begin
        rdata = rdata | map_vals[i];
      end
    end
  end

endmodule

// File: rtl/dtr_addr_split.sv
module dtr_addr_split #(
  parameter int LADDR_W = 18,
  parameter int LEN_W   = 15,
  parameter int OFF_W   = 14,
  parameter int IDX_W   = 2
) (
  input  logic [LADDR_W-1:0] addr,
  input  logic [LEN_W-1:0]   len,
  output logic               in_range,
  output logic [IDX_W-1:0]   idx,
  output logic [OFF_W-1:0]   off,
  output logic [LEN_W-1:0]   fit_len
);

  localparam int            COVER_W = OFF_W + IDX_W;
  localparam logic [OFF_W:0] BLOCK  = {1'b1, {OFF_W{1'b0}}};

  logic [OFF_W:0] room;
  logic [LEN_W-1:0] room_ext;

  always_comb begin
    in_range = ((addr >> COVER_W) == '0);
    idx      = addr[OFF_W +: IDX_W];
    off      = addr[OFF_W-1:0];
    room     = BLOCK - {1'b0, off};
    room_ext = LEN_W'(room);
    fit_len  = (len > room_ext) ? room_ext : len;
  end

endmodule

// File: rtl/dtr_phys_map.sv
module dtr_phys_map
  import dtr_pkg::*;
#(
  parameter int          OFF_W   = 14,
  parameter int          IDX_W   = 2,
  parameter int          PHYS_W  = 26,
  parameter logic [15:0] IO_BASE = 16'hC000
) (
  input  logic [MAP_W-1:0] map_val,
  input  logic [IDX_W-1:0] idx,
  input  logic [OFF_W-1:0] off,
  output logic [PHYS_W-1:0] phys,
  output space_e            space,
  output logic              reserved
);

  localparam int DSEG_SHIFT = OFF_W + IDX_W;

  logic [SEG_W-1:0]  seg;
  logic [1:0]        spc;
  logic [1:0]        nib_sel;
  logic [3:0]        nib;
  logic [PHYS_W-1:0] linear_addr;
  logic [PHYS_W-1:0] data_addr;
  logic [PHYS_W-1:0] io_addr;

  always_comb begin
    seg         = map_val[SEG_W-1:0];
    spc         = map_val[SPC_LSB +: 2];
    nib_sel     = off[IO_WIN_LSB +: 2];
    nib         = map_val[{~nib_sel, 2'b00} +: 4];
    linear_addr = (PHYS_W'(seg) << OFF_W) + PHYS_W'(off);
    data_addr   = (PHYS_W'(seg) << DSEG_SHIFT) + (PHYS_W'(idx) << OFF_W) + PHYS_W'(off);
    io_addr     = (PHYS_W'(nib) << DSEG_SHIFT) + PHYS_W'(IO_BASE) + PHYS_W'(off);
  end

  always_comb begin
    reserved = 1'b0;
    space    = SPC_UNIFIED;
    phys     = '0;
    if (map_val[IO_BIT]) begin
      space = SPC_IO;
      phys  = io_addr;
    end else begin
      case (spc)
        2'b00: begin
          space = SPC_UNIFIED;
          phys  = linear_addr;
        end
        2'b01: begin
          space = SPC_INSN;
          phys  = linear_addr;
        end
        2'b10: begin
          space = SPC_DATA;
          phys  = data_addr;
        end
        default: begin
          reserved = 1'b1;
        end
      endcase
    end
  end

endmodule

// File: rtl/dtr_xlate.sv
module dtr_xlate
  import dtr_pkg::*;
#(
  parameter int          LADDR_W      = 18,
  parameter int          LEN_W        = 15,
  parameter int          BLOCK_BYTES  = 16384,
  parameter int          NUM_MAPS     = 4,
  parameter bit          LEGACY_RESET = 1'b0,
  parameter logic [15:0] MAP_BASE     = 16'hFF08,
  parameter logic [15:0] ALIAS_ADDR   = 16'hFF04,
  parameter int          ALIAS_IDX    = 2,
  parameter logic [15:0] IO_BASE      = 16'hC000,
  localparam int         OFF_W        = $clog2(BLOCK_BYTES),
  localparam int         IDX_W        = $clog2(NUM_MAPS),
  localparam int         PHYS_W       = SEG_W + OFF_W + IDX_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic [15:0]        reg_addr,
  input  logic [15:0]        reg_wdata,
  output logic [15:0]        reg_rdata,
  input  logic               req_valid,
  input  logic [LADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]   req_len,
  output logic               rsp_valid,
  output logic [PHYS_W-1:0]  rsp_phys,
  output logic [1:0]         rsp_space,
  output logic [LEN_W-1:0]   rsp_len,
  output logic               rsp_err
);

  logic [1:0] rst_sync;
  logic       rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync <= 2'b00;
    end else begin
      rst_sync <= {rst_sync[0], 1'b1};
    end
  end

  assign rst_q_n = rst_sync[1];

  logic [NUM_MAPS-1:0][MAP_W-1:0] map_vals;
  logic                           in_range;
  logic [IDX_W-1:0]               idx;
  logic [OFF_W-1:0]               off;
  logic [LEN_W-1:0]               fit_len;
  logic [MAP_W-1:0]               sel_map;
  logic [PHYS_W-1:0]              phys;
  space_e                         space;
  logic                           reserved;

  dtr_map_regs #(
    .NUM_MAPS    (NUM_MAPS),
    .LEGACY_RESET(LEGACY_RESET),
    .MAP_BASE    (MAP_BASE),
    .ALIAS_ADDR  (ALIAS_ADDR),
    .ALIAS_IDX   (ALIAS_IDX)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .wr      (reg_wr),
    .addr    (reg_addr),
    .wdata   (reg_wdata),
    .rdata   (reg_rdata),
    .map_vals(map_vals)
  );

  dtr_addr_split #(
    .LADDR_W(LADDR_W),
    .LEN_W  (LEN_W),
    .OFF_W  (OFF_W),
    .IDX_W  (IDX_W)
  ) u_split (
    .addr    (req_addr),
    .len     (req_len),
    .in_range(in_range),
    .idx     (idx),
    .off     (off),
    .fit_len (fit_len)
  );

  assign sel_map = map_vals[idx];

  dtr_phys_map #(
    .OFF_W  (OFF_W),
    .IDX_W  (IDX_W),
    .PHYS_W (PHYS_W),
    .IO_BASE(IO_BASE)
  ) u_map (
    .map_val (sel_map),
    .idx     (idx),
    .off     (off),
    .phys    (phys),
    .space   (space),
    .reserved(reserved)
  );

  logic              fault;
  logic [PHYS_W-1:0] nxt_phys;
  space_e            nxt_space;
  logic [LEN_W-1:0]  nxt_len;

  always_comb begin
    fault     = !in_range || reserved;
    nxt_phys  = fault ? '0 : phys;
    nxt_space = fault ? SPC_UNIFIED : space;
    nxt_len   = fault ? '0 : fit_len;
  end

  logic              valid_q;
  logic [PHYS_W-1:0] phys_q;
  space_e            space_q;
  logic [LEN_W-1:0]  len_q;
  logic              err_q;

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      valid_q <= 1'b0;
    end else begin
      valid_q <= req_valid;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      phys_q  <= '0;
      space_q <= SPC_UNIFIED;
      len_q   <= '0;
      err_q   <= 1'b0;
    end else if (req_valid) begin
      phys_q  <= nxt_phys;
      space_q <= nxt_space;
      len_q   <= nxt_len;
      err_q   <= fault;
    end
  end

  assign rsp_valid = valid_q;
  assign rsp_phys  = phys_q;
  assign rsp_space = space_q;
  assign rsp_len   = len_q;
  assign rsp_err   = err_q;

endmodule

// File: rtl/dtr_xlate_chk.sv
module dtr_xlate_chk #(
  parameter int          LADDR_W    = 18,
  parameter int          LEN_W      = 15,
  parameter int          OFF_W      = 14,
  parameter int          IDX_W      = 2,
  parameter int          PHYS_W     = 26,
  parameter int          NUM_MAPS   = 4,
  parameter logic [15:0] MAP_BASE   = 16'hFF08,
  parameter logic [15:0] ALIAS_ADDR = 16'hFF04
) (
  input logic               clk,
  input logic               rst_n,
  input logic [15:0]        reg_addr,
  input logic [15:0]        reg_rdata,
  input logic               req_valid,
  input logic [LADDR_W-1:0] req_addr,
  input logic [LEN_W-1:0]   req_len,
  input logic               rsp_valid,
  input logic [PHYS_W-1:0]  rsp_phys,
  input logic [1:0]         rsp_space,
  input logic [LEN_W-1:0]   rsp_len,
  input logic               rsp_err
);

  localparam int          COVER_W = OFF_W + IDX_W;
  localparam logic [LEN_W-1:0] BLOCK_LEN = LEN_W'(1) << OFF_W;

  logic known_addr;
  always_comb begin
    known_addr = (reg_addr == ALIAS_ADDR);
    for (int i = 0; i < NUM_MAPS; i++) begin
      if (reg_addr == 16'(MAP_BASE + 16'(2 * i))) known_addr = 1'b1;
    end
  end

  assert_range_err_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && ((req_addr >> COVER_W) != '0)) |=> (rsp_valid && rsp_err));

  // R9 and R4: a fault result carries no address, length or space
  assert_err_clean_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |-> (rsp_len == '0 && rsp_phys == '0 && rsp_space == 2'd0));

  assert_len_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_len <= BLOCK_LEN && rsp_len <= $past(req_len)));

  assert_io_window_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_err && rsp_space == 2'd3) |-> (rsp_phys[COVER_W-1 -: 2] == 2'b11));

  assert_valid_rise_R11: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  assert_valid_fall_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> ($stable(rsp_phys) && $stable(rsp_len) && $stable(rsp_err)));

  assert_unmapped_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !known_addr |-> (reg_rdata == 16'h0000));

endmodule

bind dtr_xlate dtr_xlate_chk #(
  .LADDR_W   (LADDR_W),
  .LEN_W     (LEN_W),
  .OFF_W     (OFF_W),
  .IDX_W     (IDX_W),
  .PHYS_W    (PHYS_W),
  .NUM_MAPS  (NUM_MAPS),
  .MAP_BASE  (MAP_BASE),
  .ALIAS_ADDR(ALIAS_ADDR)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_q_n),
  .reg_addr (reg_addr),
  .reg_rdata(reg_rdata),
  .req_valid(req_valid),
  .req_addr (req_addr),
  .req_len  (req_len),
  .rsp_valid(rsp_valid),
  .rsp_phys (rsp_phys),
  .rsp_space(rsp_space),
  .rsp_len  (rsp_len),
  .rsp_err  (rsp_err)
);

// File: tb/tb_dtr_xlate.sv
`timescale 1ns/1ps
module tb_dtr_xlate;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic [15:0] reg_addr;
  logic [15:0] reg_wdata;
  logic [15:0] reg_rdata;
  logic        req_valid;
  logic [17:0] req_addr;
  logic [14:0] req_len;
  logic        rsp_valid;
  logic [25:0] rsp_phys;
  logic [1:0]  rsp_space;
  logic [14:0] rsp_len;
  logic        rsp_err;

  logic [15:0] leg_rdata;
  logic        leg_valid;
  logic [25:0] leg_phys;
  logic [1:0]  leg_space;
  logic [14:0] leg_len;
  logic        leg_err;

  always #2.5 clk = ~clk;

  dtr_xlate dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_valid(req_valid),
    .req_addr(req_addr), .req_len(req_len), .rsp_valid(rsp_valid),
    .rsp_phys(rsp_phys), .rsp_space(rsp_space), .rsp_len(rsp_len), .rsp_err(rsp_err)
  );

  dtr_xlate #(.LEGACY_RESET(1'b1)) dut_leg (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(leg_rdata), .req_valid(req_valid),
    .req_addr(req_addr), .req_len(req_len), .rsp_valid(leg_valid),
    .rsp_phys(leg_phys), .rsp_space(leg_space), .rsp_len(leg_len), .rsp_err(leg_err)
  );

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;
  logic [15:0] mdl [4];

  task automatic check_eq(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_sim();
    if (!done) begin
      done = 1'b1;
      $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  function automatic logic [15:0] port_addr(input int n);
    return 16'hFF08 + 16'(2 * n);
  endfunction

  // Expected result, packed as {err, space, len, phys}
  function automatic logic [43:0] expect_rsp(input logic [17:0] a, input logic [14:0] l);
    logic [1:0]  ix;
    logic [13:0] of;
    logic [15:0] m;
    logic [14:0] room;
    logic [14:0] n;
    logic [3:0]  nib;
    logic [25:0] p;
    logic [9:0]  seg;
    if (a >= 18'h10000) return 44'h0 | (44'h1 << 43);
    ix   = a[15:14];
    of   = a[13:0];
    m    = mdl[ix];
    room = 15'h4000 - {1'b0, of};
    n    = (l < room) ? l : room;
    seg  = m[9:0];
    if (m[15]) begin
      nib = 4'((m >> (4 * (3 - int'(of[13:12])))) & 16'hF);
      p   = 26'(nib) * 26'h10000 + 26'hC000 + 26'(of);
      return {1'b0, 2'd3, n, p};
    end
    case (m[13:12])
      2'b00: return {1'b0, 2'd0, n, 26'(seg) * 26'h4000 + 26'(of)};
      2'b01: return {1'b0, 2'd1, n, 26'(seg) * 26'h4000 + 26'(of)};
      2'b10: return {1'b0, 2'd2, n, (26'(seg) << 16) + 26'(ix) * 26'h4000 + 26'(of)};
      default: return 44'h0 | (44'h1 << 43);
    endcase
  endfunction

  task automatic write_reg(input logic [15:0] a, input logic [15:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    for (int n = 0; n < 4; n++) if (a == port_addr(n)) mdl[n] = d;
    if (a == 16'hFF04) mdl[2] = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic read_chk(input int n, input string req);
    reg_addr = port_addr(n);
    #1;
    check_eq(req, "map readback", 64'(reg_rdata), 64'(mdl[n]));
  endtask

  task automatic do_req(input logic [17:0] a, input logic [14:0] l, input string req);
    logic [43:0] exp;
    exp = expect_rsp(a, l);
    req_valid = 1'b1; req_addr = a; req_len = l;
    @(negedge clk);
    req_valid = 1'b0;
    check_eq(req, "rsp_valid", 64'(rsp_valid), 64'd1);
    check_eq(req, "rsp {err,space,len,phys}", 64'({rsp_err, rsp_space, rsp_len, rsp_phys}), 64'(exp));
  endtask

  initial begin
    #(5.0 * 150000);
    n_err++;
    $display("FAIL R11 watchdog: actual timeout expected completion");
    finish_sim();
  end

  initial begin
    logic [43:0] exp;
    logic [25:0] held;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = 16'h0; reg_wdata = 16'h0;
    req_valid = 1'b0; req_addr = '0; req_len = '0;
    mdl[0] = 16'h2000; mdl[1] = 16'h2000; mdl[2] = 16'h2000; mdl[3] = 16'h0000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset values, both builds
    check_eq("R1", "rsp_valid after reset", 64'(rsp_valid), 64'd0);
    for (int n = 0; n < 4; n++) read_chk(n, "R1");
    reg_addr = port_addr(2); #1;
    check_eq("R1", "legacy map word 2", 64'(leg_rdata), 64'h0);

    // R2 alias read and write, unmapped address ignored
    reg_addr = 16'hFF04; #1;
    check_eq("R2", "alias read", 64'(reg_rdata), 64'h2000);
    write_reg(16'hFF04, 16'h2155);
    read_chk(2, "R2");
    write_reg(16'hFF0A, 16'h1003);
    read_chk(1, "R2");
    write_reg(16'hFF06, 16'hFFFF);
    for (int n = 0; n < 4; n++) read_chk(n, "R2");
    reg_addr = 16'hFF06; #1;
    check_eq("R2", "unmapped read", 64'(reg_rdata), 64'h0);

    // R3 / R7: block 1 instruction space, seg 3
    do_req(18'h04005, 15'd8, "R3");
    // R8: block 2 internal data, seg 0x155
    do_req(18'h08010, 15'd4, "R8");
    // R6: unified, seg 0x3FF
    write_reg(port_addr(3), 16'h03FF);
    do_req(18'h0C123, 15'd2, "R6");
    write_reg(port_addr(0), 16'h1001);
    do_req(18'h00000, 15'd16, "R7");

    // R5 clipping at the block edge and zero length
    do_req(18'h03FFF, 15'd5, "R5");
    do_req(18'h0C000, 15'h7FFF, "R5");
    do_req(18'h04100, 15'd0, "R5");

    // R4 out of range
    do_req(18'h10000, 15'd4, "R4");
    do_req(18'h3FFFF, 15'd1, "R4");

    // R9 reserved space
    write_reg(port_addr(1), 16'h3005);
    do_req(18'h04020, 15'd4, "R9");

    // R10 I/O mode, every 4 KB window
    write_reg(port_addr(3), 16'h8A5C);
    for (int w = 0; w < 4; w++) do_req(18'h0C000 + 18'(w * 16'h1000) + 18'h00F, 15'd3, "R10");

    // R11 write in the same cycle as a request uses the old map word
    exp = expect_rsp(18'h00040, 15'd2);
    reg_wr = 1'b1; reg_addr = port_addr(0); reg_wdata = 16'h2077;
    req_valid = 1'b1; req_addr = 18'h00040; req_len = 15'd2;
    @(negedge clk);
    reg_wr = 1'b0; req_valid = 1'b0; mdl[0] = 16'h2077;
    check_eq("R11", "same-cycle write", 64'({rsp_err, rsp_space, rsp_len, rsp_phys}), 64'(exp));
    do_req(18'h00040, 15'd2, "R11");
    held = rsp_phys;
    req_addr = 18'h08000;
    @(negedge clk);
    check_eq("R11", "rsp_valid idle", 64'(rsp_valid), 64'd0);
    check_eq("R11", "phys held", 64'(rsp_phys), 64'(held));

    // Random mix
    for (int it = 0; it < 3000; it++) begin
      int r;
      r = int'($urandom % 16);
      if (r < 3) begin
        int k;
        logic [15:0] a;
        k = int'($urandom % 6);
        a = (k < 4) ? port_addr(k) : ((k == 4) ? 16'hFF04 : 16'($urandom));
        write_reg(a, 16'($urandom));
      end else if (r == 3) begin
        read_chk(int'($urandom % 4), "R2");
      end else begin
        logic [17:0] a;
        logic [14:0] l;
        a = ((($urandom % 8) == 0) ? 18'($urandom) : 18'($urandom % 32'h10000));
        if (($urandom % 4) == 0) a[13:0] = 14'h3FFF - 14'($urandom % 8);
        l = 15'($urandom % 32'h5000);
        do_req(a, l, "R6 R7 R8 R9 R10 R5 random");
      end
    end

    finish_sim();
  end

endmodule